// File: doc/BRIEF.md
# Partitioned Content-Addressable Memory with Learn

This block is a small associative store of fixed-width words. A runtime partition setting divides each stored word into two fields. The low bits form the key that lookups compare. The bits above the key are associated data, which lookups return. The array supports four single-entry commands:

- search finds an entry.
- insert places a new word in the first free slot.
- delete invalidates a matching entry.
- learn searches and, on a miss, inserts in the same cycle.

Two requesters share the array. One is a processor-side port and the other is a pipelined command port. A fixed-priority arbiter serves one of them per cycle, and the arbiter stalls the other by holding its ready low. Each accepted command produces one registered response in the following cycle. The response gives a hit flag, an index, the data field and a no-room flag. A separate level output reports when every slot is occupied.

Top module: `pcam_top`

## Requirements
- R1: The partition code `cfg_code` (2 bits) sets the key width to 32 + 16 × code bits (32, 48, 64 or 80). Only word bits below the key width are compared. The data field returned is the stored word shifted right by the key width, keeping its low 48 bits, so code 3 returns all-zero data.
- R2: A search returns `rsp_hit`=1, the lowest index among valid entries whose key bits match, and that entry's data field. On a miss it returns hit 0, index 0 and data 0.
- R3: An insert writes the command word into the lowest-index invalid slot and returns that index with `rsp_hit`=0 and `rsp_full`=0. No duplicate check is made.
- R4: An insert while all slots are valid returns `rsp_full`=1 and `rsp_hit`=0, and writes nothing.
- R5: A delete of a matching key clears the lowest matching entry and returns hit 1 with its index. A delete of a missing key returns hit 0 and changes no entry.
- R6: A learn of a present key returns hit 1, the index and the data field, and leaves the array unchanged. A learn of an absent key behaves as an insert: it returns the slot written, or `rsp_full`=1 when no slot is free.
- R7: Op encoding is 0 search, 1 insert, 2 delete, 3 learn. Port A always has priority and `a_ready` is 1. While `a_valid` is high, `b_ready` is low and a port B request waits.
- R8: A command accepted at a clock edge gives `rsp_valid`=1 after that edge, for one cycle. `rsp_port` is 0 for port A and 1 for port B. `rsp_valid` is 0 after an edge with no accepted command.
- R9: `cfg_we` updates the partition only at an edge where neither port is requesting. A write attempted while a request is present is ignored.
- R10: `full` is 1 exactly when every slot is valid. It reflects the array after the most recent edge.
- R11: After reset all slots are invalid, the partition code is 0, and `rsp_valid` and `full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Port A command request |
| a_ready | output | 1 | Port A accepted this cycle |
| a_op | input | 2 | Port A command code |
| a_word | input | 80 | Port A key/data word |
| b_valid | input | 1 | Port B command request |
| b_ready | output | 1 | Port B accepted this cycle |
| b_op | input | 2 | Port B command code |
| b_word | input | 80 | Port B key/data word |
| cfg_we | input | 1 | Partition write strobe |
| cfg_code | input | 2 | New partition code |
| rsp_valid | output | 1 | Response present |
| rsp_port | output | 1 | Port that issued the response |
| rsp_hit | output | 1 | Key found |
| rsp_index | output | 4 | Matched or written slot |
| rsp_data | output | 48 | Data field of matched entry |
| rsp_full | output | 1 | Insert or learn found no free slot |
| full | output | 1 | All slots valid |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a request from each port. The bench raises both ports in one cycle with port A inserting a key and port B learning the same key. Port B must see ready low in that cycle, and when it is granted one cycle later its learn must hit the slot that port A just wrote. The second pair is a partition write and a command. The bench issues them together and then probes with keys that differ only in bits above the old key width, to show that the old partition stayed in force.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
    typedef enum logic [1:0] {
        OP_SEARCH = 2'd0,
        OP_INSERT = 2'd1,
        OP_DELETE = 2'd2,
        OP_LEARN  = 2'd3
    } pcam_op_e;
endpackage

// File: rtl/pcam_arbiter.sv
module pcam_arbiter #(
    parameter int NPORTS = 2
) (
    input  logic [NPORTS-1:0] req,
    output logic [NPORTS-1:0] gnt,
    output logic [NPORTS-1:0] ready,
    output logic              any_req
);
    logic [NPORTS:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar p = 0; p < NPORTS; p++) begin : g_pri
        assign gnt[p]       = req[p] & ~blocked[p];
        assign ready[p]     = ~blocked[p];
        assign blocked[p+1] = blocked[p] | req[p];
    end

    assign any_req = blocked[NPORTS];
endmodule

// File: rtl/pcam_match.sv
module pcam_match #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 80,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WORD_W-1:0] words,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [WORD_W-1:0]              key,
    input  logic [WORD_W-1:0]              mask,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           free,
    output logic [IDX_W-1:0]               free_idx
);
    logic [ENTRIES-1:0] line_hit;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_line
        assign line_hit[e] = valid[e] && (((words[e] ^ key) & mask) == '0);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (line_hit[e]) hit_idx  = IDX_W'(e);
            if (!valid[e])   free_idx = IDX_W'(e);
        end
    end

    assign hit  = |line_hit;
    assign free = ~&valid;
endmodule

// File: rtl/pcam_store.sv
module pcam_store #(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 80,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WORD_W-1:0]              wr_word,
    input  logic                           clr_en,
    input  logic [IDX_W-1:0]               clr_idx,
    output logic [ENTRIES-1:0][WORD_W-1:0] words,
    output logic [ENTRIES-1:0]             valid
);
    typedef struct packed {
        logic [ENTRIES-1:0][WORD_W-1:0] words;
        logic [ENTRIES-1:0]             valid;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.words[wr_idx] = wr_word;
            st_d.valid[wr_idx] = 1'b1;
        end
        if (clr_en) begin
            st_d.valid[clr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.words;
    assign valid = st_q.valid;
endmodule

// File: rtl/pcam_top.sv
module pcam_top #(
    parameter int ENTRIES  = 16,
    parameter int WORD_W   = 80,
    parameter int KEY_MIN  = 32,
    parameter int KEY_STEP = 16,
    parameter int LEVELS   = (WORD_W - KEY_MIN) / KEY_STEP + 1,
    parameter int CODE_W   = $clog2(LEVELS),
    parameter int IDX_W    = $clog2(ENTRIES),
    parameter int DATA_W   = WORD_W - KEY_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic [1:0]        a_op,
    input  logic [WORD_W-1:0] a_word,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [1:0]        b_op,
    input  logic [WORD_W-1:0] b_word,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              rsp_valid,
    output logic              rsp_port,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_index,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_full,
    output logic              full
);
    import pcam_pkg::*;

    localparam int NPORTS = 2;

    typedef struct packed {
        logic [CODE_W-1:0] part;
        logic              rsp_valid;
        logic              rsp_port;
        logic              rsp_hit;
        logic [IDX_W-1:0]  rsp_index;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_full;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NPORTS-1:0] gnt, rdy;
    logic              accept;
    pcam_op_e          sel_op;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] key_mask;
    logic [CODE_W-1:0] part_q;
    int                key_w;

    logic [ENTRIES-1:0][WORD_W-1:0] words;
    logic [ENTRIES-1:0]             valid;
    logic                           m_hit, m_free;
    logic [IDX_W-1:0]               m_hit_idx, m_free_idx;
    logic                           wr_en, clr_en;

    pcam_arbiter #(.NPORTS(NPORTS)) i_arb (
        .req     ({b_valid, a_valid}),
        .gnt     (gnt),
        .ready   (rdy),
        .any_req (accept)
    );

    assign a_ready = rdy[0];
    assign b_ready = rdy[1];

    assign sel_op   = pcam_op_e'(gnt[0] ? a_op : b_op);
    assign sel_word = gnt[0] ? a_word : b_word;
    assign part_q   = ctl_q.part;

    always_comb begin
        int lvl;
        lvl = int'(part_q);
        if (lvl > LEVELS - 1) lvl = LEVELS - 1;
        key_w = KEY_MIN + KEY_STEP * lvl;
        for (int b = 0; b < WORD_W; b++) begin
            key_mask[b] = (b < key_w);
        end
    end

    pcam_match #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W)) i_match (
        .words    (words),
        .valid    (valid),
        .key      (sel_word),
        .mask     (key_mask),
        .hit      (m_hit),
        .hit_idx  (m_hit_idx),
        .free     (m_free),
        .free_idx (m_free_idx)
    );

    pcam_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W), .IDX_W(IDX_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (m_free_idx),
        .wr_word (sel_word),
        .clr_en  (clr_en),
        .clr_idx (m_hit_idx),
        .words   (words),
        .valid   (valid)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = accept;
        wr_en           = 1'b0;
        clr_en          = 1'b0;

        if (cfg_we && !accept) begin
            ctl_d.part = cfg_code;
        end

        if (accept) begin
            ctl_d.rsp_port  = gnt[1];
            ctl_d.rsp_hit   = 1'b0;
            ctl_d.rsp_index = '0;
            ctl_d.rsp_data  = '0;
            ctl_d.rsp_full  = 1'b0;
            case (sel_op)
                OP_SEARCH: begin
                    if (m_hit) begin
                        ctl_d.rsp_hit   = 1'b1;
                        ctl_d.rsp_index = m_hit_idx;
                        ctl_d.rsp_data  = DATA_W'(words[m_hit_idx] >> key_w);
                    end
                end
                OP_INSERT: begin
                    if (m_free) begin
                        wr_en           = 1'b1;
                        ctl_d.rsp_index = m_free_idx;
                    end else begin
                        ctl_d.rsp_full  = 1'b1;
                    end
                end
                OP_DELETE: begin
                    if (m_hit) begin
                        clr_en          = 1'b1;
                        ctl_d.rsp_hit   = 1'b1;
                        ctl_d.rsp_index = m_hit_idx;
                    end
                end
                OP_LEARN: begin
                    if (m_hit) begin
                        ctl_d.rsp_hit   = 1'b1;
                        ctl_d.rsp_index = m_hit_idx;
                        ctl_d.rsp_data  = DATA_W'(words[m_hit_idx] >> key_w);
                    end else if (m_free) begin
                        wr_en           = 1'b1;
                        ctl_d.rsp_index = m_free_idx;
                    end else begin
                        ctl_d.rsp_full  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_port  = ctl_q.rsp_port;
    assign rsp_hit   = ctl_q.rsp_hit;
    assign rsp_index = ctl_q.rsp_index;
    assign rsp_data  = ctl_q.rsp_data;
    assign rsp_full  = ctl_q.rsp_full;
    assign full      = &valid;
endmodule

// File: rtl/pcam_checker.sv
module pcam_checker #(
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_valid,
    input logic              b_valid,
    input logic              b_ready,
    input logic              rsp_valid,
    input logic              rsp_port,
    input logic              rsp_hit,
    input logic              rsp_full,
    input logic              full,
    input logic [CODE_W-1:0] part_q
);
    AST_B_STALLED: assert property (@(posedge clk) disable iff (!rst_n) a_valid |-> !b_ready); // R7
    AST_A_WINS: assert property (@(posedge clk) disable iff (!rst_n) a_valid |=> (rsp_valid && !rsp_port)); // R7
    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (a_valid || b_valid) |=> rsp_valid); // R8
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(a_valid || b_valid) |=> !rsp_valid); // R8
    AST_PART_HELD: assert property (@(posedge clk) disable iff (!rst_n) (a_valid || b_valid) |=> $stable(part_q)); // R9
    AST_NO_ROOM: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_full) |-> (full && !rsp_hit)); // R4
endmodule

bind pcam_top pcam_checker #(.CODE_W(CODE_W)) i_pcam_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_valid   (a_valid),
    .b_valid   (b_valid),
    .b_ready   (b_ready),
    .rsp_valid (rsp_valid),
    .rsp_port  (rsp_port),
    .rsp_hit   (rsp_hit),
    .rsp_full  (rsp_full),
    .full      (full),
    .part_q    (part_q)
);

// File: tb/test_pcam_top.sv
module test_pcam_top;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int WW = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_valid = 1'b0, b_valid = 1'b0;
    logic          a_ready, b_ready;
    logic [1:0]    a_op = '0, b_op = '0;
    logic [WW-1:0] a_word = '0, b_word = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_code = '0;
    logic          rsp_valid, rsp_port, rsp_hit, rsp_full, full;
    logic [3:0]    rsp_index;
    logic [47:0]   rsp_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [WW-1:0] m_word [N];
    bit            m_valid [N];
    int            m_code = 0;

    logic          e_hit, e_full;
    logic [3:0]    e_idx;
    logic [47:0]   e_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcam_top i_pcam_top (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_op(a_op), .a_word(a_word),
        .b_valid(b_valid), .b_ready(b_ready), .b_op(b_op), .b_word(b_word),
        .cfg_we(cfg_we), .cfg_code(cfg_code),
        .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_hit(rsp_hit),
        .rsp_index(rsp_index), .rsp_data(rsp_data), .rsp_full(rsp_full), .full(full)
    );

    task automatic chk(input string req, input string what, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] wd(input int i);
        logic [15:0] s;
        s = 16'(i);
        return {16'h5A00 + s, 16'h3C00 + s, 16'h9900 + s, 32'h1000_0000 + 32'(i)};
    endfunction

    function automatic int kw();
        return 32 + 16 * m_code;
    endfunction

    function automatic bit model_all_valid();
        for (int e = 0; e < N; e++) if (!m_valid[e]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_find(input logic [WW-1:0] w, output bit h, output int idx);
        logic [WW-1:0] msk;
        msk = '0;
        for (int b = 0; b < WW; b++) msk[b] = (b < kw());
        h = 1'b0; idx = 0;
        for (int e = N - 1; e >= 0; e--) begin
            if (m_valid[e] && (((m_word[e] ^ w) & msk) == '0)) begin
                h = 1'b1; idx = e;
            end
        end
    endtask

    task automatic model_free(output bit f, output int idx);
        f = 1'b0; idx = 0;
        for (int e = N - 1; e >= 0; e--) if (!m_valid[e]) begin f = 1'b1; idx = e; end
    endtask

    task automatic model_step(input logic [1:0] op, input logic [WW-1:0] w);
        bit h, f;
        int hi, fi;
        logic [WW-1:0] sh;
        model_find(w, h, hi);
        model_free(f, fi);
        e_hit = 1'b0; e_idx = '0; e_data = '0; e_full = 1'b0;
        sh = m_word[hi] >> kw();
        if ((op == 2'd0 || op == 2'd3) && h) begin
            e_hit = 1'b1; e_idx = 4'(hi); e_data = sh[47:0];
        end else if (op == 2'd2) begin
            if (h) begin e_hit = 1'b1; e_idx = 4'(hi); m_valid[hi] = 1'b0; end
        end else if (op == 2'd1 || op == 2'd3) begin
            if (f) begin e_idx = 4'(fi); m_word[fi] = w; m_valid[fi] = 1'b1; end
            else e_full = 1'b1;
        end
    endtask

    task automatic compare(input string req, input bit port);
        chk(req, "rsp_valid", WW'(rsp_valid), WW'(1));
        chk(req, "rsp_port",  WW'(rsp_port),  WW'(port));
        chk(req, "rsp_hit",   WW'(rsp_hit),   WW'(e_hit));
        chk(req, "rsp_index", WW'(rsp_index), WW'(e_idx));
        chk(req, "rsp_data",  WW'(rsp_data),  WW'(e_data));
        chk(req, "rsp_full",  WW'(rsp_full),  WW'(e_full));
        chk("R10", "full",    WW'(full),      WW'(model_all_valid()));
    endtask

    task automatic drive(input bit port, input logic [1:0] op, input logic [WW-1:0] w);
        if (port) begin b_valid = 1'b1; b_op = op; b_word = w; end
        else      begin a_valid = 1'b1; a_op = op; a_word = w; end
    endtask

    task automatic op_check(input string req, input bit port, input logic [1:0] op, input logic [WW-1:0] w);
        @(negedge clk);
        drive(port, op, w);
        @(posedge clk);
        #1;
        a_valid = 1'b0; b_valid = 1'b0;
        model_step(op, w);
        compare(req, port);
    endtask

    task automatic set_cfg(input int code);
        @(negedge clk);
        cfg_we = 1'b1; cfg_code = 2'(code);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        m_code = code;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        for (int e = 0; e < N; e++) begin m_word[e] = '0; m_valid[e] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state
        chk("R11", "rsp_valid", WW'(rsp_valid), WW'(0));
        chk("R11", "full",      WW'(full),      WW'(0));
        chk("R7",  "a_ready",   WW'(a_ready),   WW'(1));
        chk("R7",  "b_ready",   WW'(b_ready),   WW'(1));
        op_check("R11", 0, 2'd0, wd(0));

        // R3 fill from both ports
        for (int i = 0; i < N; i++) op_check("R3", i[0], 2'd1, wd(i));
        // R4 insert into full array is rejected
        op_check("R4", 0, 2'd1, wd(20));
        op_check("R4", 1, 2'd0, wd(20));

        // R8 quiet cycle after a response
        @(posedge clk); #1;
        chk("R8", "rsp_valid idle", WW'(rsp_valid), WW'(0));

        // R1 / R2 sweep over partition codes and key variants
        for (int c = 0; c < 4; c++) begin
            set_cfg(c);
            for (int i = 0; i < N; i++) begin
                op_check("R2", i[0], 2'd0, wd(i));
                op_check("R1", 0, 2'd0, wd(i) ^ (80'h1 << 40));
                op_check("R1", 1, 2'd0, wd(i) ^ (80'h1 << 70));
            end
            op_check("R2", 0, 2'd0, wd(30));
        end

        // R5 deletes
        set_cfg(0);
        for (int i = 0; i < N; i += 2) op_check("R5", 1, 2'd2, wd(i));
        op_check("R5", 0, 2'd2, wd(0));
        op_check("R5", 0, 2'd0, wd(2));
        op_check("R5", 1, 2'd0, wd(3));

        // R6 learn
        op_check("R6", 0, 2'd3, wd(1));
        op_check("R6", 1, 2'd3, wd(40));
        op_check("R6", 0, 2'd3, wd(40));
        op_check("R6", 1, 2'd0, wd(40));

        // R9 partition write with a request present is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_code = 2'd3;
        drive(0, 2'd0, wd(1) ^ (80'h1 << 70));
        @(posedge clk); #1;
        cfg_we = 1'b0; a_valid = 1'b0;
        model_step(2'd0, wd(1) ^ (80'h1 << 70));
        compare("R9", 0);
        op_check("R9", 0, 2'd0, wd(1) ^ (80'h1 << 70));
        set_cfg(3);
        op_check("R9", 1, 2'd0, wd(1) ^ (80'h1 << 70));
        set_cfg(0);

        // R7 both ports in one cycle: A inserts, B learns same key
        @(negedge clk);
        drive(0, 2'd1, wd(50));
        drive(1, 2'd3, wd(50));
        #1;
        chk("R7", "b_ready contended", WW'(b_ready), WW'(0));
        chk("R7", "a_ready contended", WW'(a_ready), WW'(1));
        @(posedge clk); #1;
        model_step(2'd1, wd(50));
        compare("R7", 0);
        @(negedge clk);
        a_valid = 1'b0;
        #1;
        chk("R7", "b_ready granted", WW'(b_ready), WW'(1));
        @(posedge clk); #1;
        b_valid = 1'b0;
        model_step(2'd3, wd(50));
        compare("R7", 1);

        // R6 learn with no free slot
        cnt = 100;
        while (!model_all_valid()) begin
            op_check("R3", 0, 2'd1, wd(cnt));
            cnt++;
        end
        op_check("R6", 1, 2'd3, wd(60));
        op_check("R6", 0, 2'd0, wd(60));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule